// File: doc/BRIEF.md
# Nine-Bit Configurable Register Bank

This block is a bank of nine single-bit storage elements that sits beside a group of eight logic outputs. Eight elements form two nibbles (`q[3:0]` and `q[7:4]`); the ninth (`q[8]`) stands alone and always captures `carry_in`. For the eight nibble bits, a shared source-select line chooses between the combinational result (`lut_res`) and a direct data bit (`dir_in`) as the next value.

A shared clock, clock enable and set/reset line control the bank. Static configuration inputs can invert each of these controls and the clock. They can switch clock enable and set/reset off separately for the lower nibble, the upper nibble and the ninth element. They select whether set/reset acts synchronously or asynchronously, and they give each element its own forced value. An active-low asynchronous global reset forces every element to its own forced value unless a bank-wide mask switches it off.

Inside, a decoder turns the configuration and the live controls into one control word per group. Each control word carries a load enable, a synchronous clear and an asynchronous clear. The set/reset behaviour of each group is held as one of three named modes:
- `SR_OFF`: set/reset is disabled for the group.
- `SR_SYNC`: set/reset is taken at the capture edge.
- `SR_ASYNC`: set/reset forces the group at once.

The mode of a group changes only when its configuration changes. No state advances on its own.

Top module: `nrb_bank`

## Requirements
- R1: With `cfg_glb_mask`=0, holding `glb_rst_n` low forces every `q[i]` to `cfg_init[i]` at once, without a clock edge, and keeps it there while low.
- R2: With `cfg_glb_mask`=1, `glb_rst_n` has no effect: the bank holds and loads exactly as if it were high.
- R3: The effective select is `cfg_sel_en & (src_sel ^ cfg_sel_inv)`. When it is 1 the nibble bits load `lut_res`; when it is 0 they load `dir_in`, so with `cfg_sel_en`=0 they always load `dir_in`. `q[8]` always loads `carry_in`.
- R4: Group index g is 0 for `q[3:0]`, 1 for `q[7:4]` and 2 for `q[8]`. When `cfg_ce_en[g]`=1 and `clk_en ^ cfg_ce_inv` is 0, group g holds across a capture edge. When `cfg_ce_en[g]`=0, group g loads on every capture edge.
- R5: With `cfg_sr_async`=0, `cfg_sr_en[g]`=1 and `sr ^ cfg_sr_inv` = 1, group g loads its `cfg_init` bits at the next capture edge, whatever the clock enable and data are.
- R6: With `cfg_sr_async`=1, `cfg_sr_en[g]`=1 and set/reset active, group g takes its `cfg_init` bits immediately, without a clock edge, and holds them while set/reset stays active.
- R7: With `cfg_sr_en[g]`=0, `sr` has no effect on group g, which keeps following its clock enable and data.
- R8: `cfg_ce_inv`, `cfg_sr_inv` and `cfg_sel_inv` make their controls active low. `cfg_clk_inv`=1 moves the capture edge from the rising to the falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| glb_rst_n | input | 1 | Global asynchronous reset, active low |
| clk_en | input | 1 | Shared clock enable (polarity by `cfg_ce_inv`) |
| sr | input | 1 | Shared set/reset (polarity by `cfg_sr_inv`) |
| src_sel | input | 1 | Data source select (polarity by `cfg_sel_inv`) |
| lut_res | input | 8 | Combinational result bits for `q[7:0]` |
| dir_in | input | 8 | Direct data bits for `q[7:0]` |
| carry_in | input | 1 | Data input of the ninth element |
| cfg_clk_inv | input | 1 | 1: capture on the falling clock edge |
| cfg_ce_inv | input | 1 | 1: clock enable active low |
| cfg_sr_inv | input | 1 | 1: set/reset active low |
| cfg_sel_inv | input | 1 | 1: select active low |
| cfg_sel_en | input | 1 | 0: select ignored, direct data always used |
| cfg_sr_async | input | 1 | 1: set/reset asynchronous, 0: synchronous |
| cfg_glb_mask | input | 1 | 1: global reset ignored for the whole bank |
| cfg_ce_en | input | 3 | Per-group clock-enable use (bit g for group g) |
| cfg_sr_en | input | 3 | Per-group set/reset use (bit g for group g) |
| cfg_init | input | 9 | Forced value of each element |
| q | output | 9 | Stored bits |

## Verification
The asynchronous paths are the hardest case to reach. The check has to show that a group is forced between edges, while the other groups and the masked global reset leave the outputs untouched. The bench drives the set/reset and global reset two nanoseconds after a rising edge and samples one nanosecond later, before any capture edge can occur. It repeats this for all eight group-enable patterns in both set/reset modes and compares the result to a reference model. The falling-edge clock option is reached by switching it while every group holds, then sampling between the two clock edges.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

    typedef enum logic [1:0] {
        SR_OFF   = 2'd0,
        SR_SYNC  = 2'd1,
        SR_ASYNC = 2'd2
    } sr_mode_e;

    typedef struct packed {
        logic load_en;
        logic sync_clr;
        logic async_clr;
    } grp_ctl_t;

endpackage

// File: rtl/nrb_ctl_decode.sv
module nrb_ctl_decode
    import nrb_pkg::*;
#(
    parameter int GRP_N = 3
) (
    input  logic                   glb_rst_n,
    input  logic                   clk_en,
    input  logic                   sr,
    input  logic                   src_sel,
    input  logic                   cfg_ce_inv,
    input  logic                   cfg_sr_inv,
    input  logic                   cfg_sel_inv,
    input  logic                   cfg_sel_en,
    input  logic                   cfg_sr_async,
    input  logic                   cfg_glb_mask,
    input  logic [GRP_N-1:0]       cfg_ce_en,
    input  logic [GRP_N-1:0]       cfg_sr_en,
    output grp_ctl_t [GRP_N-1:0]   ctl,
    output logic                   sel_eff
);

    logic ce_act;
    logic sr_act;
    logic glb_hit;

    assign ce_act  = clk_en ^ cfg_ce_inv;
    assign sr_act  = sr ^ cfg_sr_inv;
    assign glb_hit = ~glb_rst_n & ~cfg_glb_mask;
    assign sel_eff = cfg_sel_en & (src_sel ^ cfg_sel_inv);

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        sr_mode_e mode;
        grp_ctl_t c;

        always_comb begin
            if (!cfg_sr_en[g])     mode = SR_OFF;
            else if (cfg_sr_async) mode = SR_ASYNC;
            else                   mode = SR_SYNC;
        end

        always_comb begin
            c.load_en   = ~cfg_ce_en[g] | ce_act;
            c.sync_clr  = 1'b0;
            c.async_clr = glb_hit;
            unique case (mode)
                SR_OFF: begin
                    c.sync_clr  = 1'b0;
                end
                SR_SYNC: begin
                    c.sync_clr  = sr_act;
                end
                SR_ASYNC: begin
                    c.async_clr = glb_hit | sr_act;
                end
                default: begin
                    c.sync_clr  = 1'b0;
                end
            endcase
        end

        assign ctl[g] = c;
    end

endmodule

// File: rtl/nrb_cell_group.sv
module nrb_cell_group
    import nrb_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         eclk,
    input  grp_ctl_t     ctl,
    input  logic         sel_eff,
    input  logic [W-1:0] init_val,
    input  logic [W-1:0] d_dir,
    input  logic [W-1:0] d_res,
    output logic [W-1:0] q
);

    logic aclr;
    logic sclr;
    logic ld;

    assign aclr = ctl.async_clr;
    assign sclr = ctl.sync_clr;
    assign ld   = ctl.load_en;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic d_pick;
        assign d_pick = sel_eff ? d_res[i] : d_dir[i];

        always_ff @(posedge eclk or posedge aclr) begin
            if (aclr)      q[i] <= init_val[i];
            else if (sclr) q[i] <= init_val[i];
            else if (ld)   q[i] <= d_pick;
        end
    end

endmodule

// File: rtl/nrb_bank.sv
module nrb_bank
    import nrb_pkg::*;
#(
    parameter  int NIB_W   = 4,
    parameter  int NUM_NIB = 2,
    localparam int DATA_W  = NIB_W * NUM_NIB,
    localparam int GRP_N   = NUM_NIB + 1
) (
    input  logic              clk,
    input  logic              glb_rst_n,
    input  logic              clk_en,
    input  logic              sr,
    input  logic              src_sel,
    input  logic [DATA_W-1:0] lut_res,
    input  logic [DATA_W-1:0] dir_in,
    input  logic              carry_in,
    input  logic              cfg_clk_inv,
    input  logic              cfg_ce_inv,
    input  logic              cfg_sr_inv,
    input  logic              cfg_sel_inv,
    input  logic              cfg_sel_en,
    input  logic              cfg_sr_async,
    input  logic              cfg_glb_mask,
    input  logic [GRP_N-1:0]  cfg_ce_en,
    input  logic [GRP_N-1:0]  cfg_sr_en,
    input  logic [DATA_W:0]   cfg_init,
    output logic [DATA_W:0]   q
);

    logic                 eclk;
    logic                 sel_eff;
    grp_ctl_t [GRP_N-1:0] ctl;

    // One shared capture clock; polarity chosen for the whole bank.
    assign eclk = clk ^ cfg_clk_inv;

    nrb_ctl_decode #(.GRP_N(GRP_N)) u_dec (
        .glb_rst_n    (glb_rst_n),
        .clk_en       (clk_en),
        .sr           (sr),
        .src_sel      (src_sel),
        .cfg_ce_inv   (cfg_ce_inv),
        .cfg_sr_inv   (cfg_sr_inv),
        .cfg_sel_inv  (cfg_sel_inv),
        .cfg_sel_en   (cfg_sel_en),
        .cfg_sr_async (cfg_sr_async),
        .cfg_glb_mask (cfg_glb_mask),
        .cfg_ce_en    (cfg_ce_en),
        .cfg_sr_en    (cfg_sr_en),
        .ctl          (ctl),
        .sel_eff      (sel_eff)
    );

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
        nrb_cell_group #(.W(NIB_W)) u_grp (
            .eclk     (eclk),
            .ctl      (ctl[n]),
            .sel_eff  (sel_eff),
            .init_val (cfg_init[n*NIB_W +: NIB_W]),
            .d_dir    (dir_in[n*NIB_W +: NIB_W]),
            .d_res    (lut_res[n*NIB_W +: NIB_W]),
            .q        (q[n*NIB_W +: NIB_W])
        );
    end

    // Lone element: both data legs carry the general input.
    nrb_cell_group #(.W(1)) u_lone (
        .eclk     (eclk),
        .ctl      (ctl[NUM_NIB]),
        .sel_eff  (sel_eff),
        .init_val (cfg_init[DATA_W]),
        .d_dir    (carry_in),
        .d_res    (carry_in),
        .q        (q[DATA_W])
    );

endmodule

// File: rtl/nrb_bank_chk.sv
module nrb_bank_chk #(
    parameter  int NIB_W   = 4,
    parameter  int NUM_NIB = 2,
    localparam int DATA_W  = NIB_W * NUM_NIB,
    localparam int GRP_N   = NUM_NIB + 1
) (
    input logic              clk,
    input logic              glb_rst_n,
    input logic              clk_en,
    input logic              sr,
    input logic              src_sel,
    input logic [DATA_W-1:0] lut_res,
    input logic [DATA_W-1:0] dir_in,
    input logic              carry_in,
    input logic              cfg_clk_inv,
    input logic              cfg_ce_inv,
    input logic              cfg_sr_inv,
    input logic              cfg_sel_inv,
    input logic              cfg_sel_en,
    input logic              cfg_sr_async,
    input logic              cfg_glb_mask,
    input logic [GRP_N-1:0]  cfg_ce_en,
    input logic [GRP_N-1:0]  cfg_sr_en,
    input logic [DATA_W:0]   cfg_init,
    input logic [DATA_W:0]   q
);

    logic ce_on;
    logic sr_on;
    logic [2*GRP_N+DATA_W+8:0] cfg_all;

    assign ce_on   = clk_en ^ cfg_ce_inv;
    assign sr_on   = sr ^ cfg_sr_inv;
    assign cfg_all = {cfg_clk_inv, cfg_ce_inv, cfg_sr_inv, cfg_sel_inv, cfg_sel_en,
                      cfg_sr_async, cfg_glb_mask, cfg_ce_en, cfg_sr_en, cfg_init,
                      1'b0};

    // R1: an unmasked global reset leaves the bank at its forced values.
    a_r1_glb_force: assert property (@(posedge clk)
        (!glb_rst_n && !cfg_glb_mask) |=> (q == cfg_init || !$stable(cfg_all)));

    // R4: lower nibble holds when its enable is in use and inactive.
    a_r4_lo_hold: assert property (@(posedge clk) disable iff (!glb_rst_n)
        (!cfg_clk_inv && cfg_ce_en[0] && !ce_on && !(cfg_sr_en[0] && sr_on))
        |=> ($stable(q[NIB_W-1:0]) || !$stable(cfg_all) || (cfg_sr_en[0] && sr_on)));

    // R5: synchronous set/reset of the upper nibble lands at the next edge.
    a_r5_hi_sync: assert property (@(posedge clk) disable iff (!glb_rst_n)
        (!cfg_clk_inv && !cfg_sr_async && cfg_sr_en[1] && sr_on)
        |=> (q[2*NIB_W-1:NIB_W] == cfg_init[2*NIB_W-1:NIB_W] || !$stable(cfg_all)));

    // R6: asynchronous set/reset keeps the lone element at its forced value.
    a_r6_lone_async: assert property (@(posedge clk)
        (cfg_sr_async && cfg_sr_en[NUM_NIB] && sr_on && $stable(cfg_all))
        |-> (q[DATA_W] == cfg_init[DATA_W]));

    // R3: lone element follows the general input whenever it loads.
    a_r3_lone_data: assert property (@(posedge clk) disable iff (!glb_rst_n)
        (!cfg_clk_inv && (!cfg_ce_en[NUM_NIB] || ce_on) && !(cfg_sr_en[NUM_NIB] && sr_on))
        |=> (q[DATA_W] == $past(carry_in) || !$stable(cfg_all)
             || (cfg_sr_en[NUM_NIB] && sr_on)));

endmodule

bind nrb_bank nrb_bank_chk #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_chk (.*);

// File: tb/tb_nrb_bank.sv
module tb_nrb_bank;

    logic       clk = 1'b0;
    logic       glb_rst_n, clk_en, sr, src_sel, carry_in;
    logic [7:0] lut_res, dir_in;
    logic       cfg_clk_inv, cfg_ce_inv, cfg_sr_inv, cfg_sel_inv, cfg_sel_en;
    logic       cfg_sr_async, cfg_glb_mask;
    logic [2:0] cfg_ce_en, cfg_sr_en;
    logic [8:0] cfg_init;
    logic [8:0] q;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [8:0] INIT = 9'h1A5;

    always #4 clk = ~clk;

    nrb_bank dut (
        .clk(clk), .glb_rst_n(glb_rst_n), .clk_en(clk_en), .sr(sr),
        .src_sel(src_sel), .lut_res(lut_res), .dir_in(dir_in),
        .carry_in(carry_in), .cfg_clk_inv(cfg_clk_inv), .cfg_ce_inv(cfg_ce_inv),
        .cfg_sr_inv(cfg_sr_inv), .cfg_sel_inv(cfg_sel_inv),
        .cfg_sel_en(cfg_sel_en), .cfg_sr_async(cfg_sr_async),
        .cfg_glb_mask(cfg_glb_mask), .cfg_ce_en(cfg_ce_en),
        .cfg_sr_en(cfg_sr_en), .cfg_init(cfg_init), .q(q)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: q=%h expected %h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    function automatic int grp_of(input int i);
        return (i < 4) ? 0 : ((i < 8) ? 1 : 2);
    endfunction

    // Reference: value after one rising capture edge.
    function automatic logic [8:0] mdl_next(input logic [8:0] cur);
        logic [8:0] nx;
        for (int i = 0; i < 9; i++) begin
            int g = grp_of(i);
            if (cfg_sr_en[g] && (sr ^ cfg_sr_inv))          nx[i] = cfg_init[i];
            else if (cfg_ce_en[g] && !(clk_en ^ cfg_ce_inv)) nx[i] = cur[i];
            else if (i == 8)                                 nx[i] = carry_in;
            else if (cfg_sel_en && (src_sel ^ cfg_sel_inv))  nx[i] = lut_res[i];
            else                                             nx[i] = dir_in[i];
        end
        return nx;
    endfunction

    // Reference: value right after async set/reset rises, no edge.
    function automatic logic [8:0] mdl_async(input logic [8:0] cur);
        logic [8:0] nx;
        for (int i = 0; i < 9; i++)
            nx[i] = cfg_sr_en[grp_of(i)] ? cfg_init[i] : cur[i];
        return nx;
    endfunction

    task automatic t_reset;
        step;
        chk("R1 reset state", q, INIT);
        glb_rst_n = 1'b1;
        clk_en = 1'b1; dir_in = 8'h3C; carry_in = 1'b0;
        step;
        chk("R3 load after reset", q, 9'h03C);
        glb_rst_n = 1'b0;
        #1 chk("R1 async global force", q, INIT);
        step;
        chk("R1 held while low", q, INIT);
        glb_rst_n = 1'b1;
    endtask

    task automatic t_mask;
        cfg_glb_mask = 1'b1;
        dir_in = 8'h77; carry_in = 1'b1;
        step;
        chk("R2 load", q, 9'h177);
        glb_rst_n = 1'b0;
        #1 chk("R2 masked no force", q, 9'h177);
        cfg_ce_en = 3'b111; clk_en = 1'b0; dir_in = 8'h11;
        step;
        chk("R2 hold under masked reset", q, 9'h177);
        clk_en = 1'b1;
        step;
        chk("R2 load under masked reset", q, 9'h111);
        glb_rst_n = 1'b1;
        cfg_glb_mask = 1'b0;
        cfg_ce_en = 3'b000;
    endtask

    task automatic t_select;
        cfg_sel_en = 1'b1; src_sel = 1'b1;
        lut_res = 8'hA5; dir_in = 8'h5A; carry_in = 1'b0;
        step;
        chk("R3 select result", q, 9'h0A5);
        src_sel = 1'b0; carry_in = 1'b1;
        step;
        chk("R3 select direct", q, 9'h15A);
        cfg_sel_en = 1'b0; src_sel = 1'b1; dir_in = 8'hC6;
        step;
        chk("R3 select disabled", q, 9'h1C6);
    endtask

    task automatic t_ce_matrix;
        for (int en = 0; en < 8; en++) begin
            logic [8:0] exp;
            cfg_ce_en = en[2:0];
            clk_en = 1'b1; dir_in = 8'h96; carry_in = 1'b1;
            step;
            chk("R4 preload", q, 9'h196);
            clk_en = 1'b0; dir_in = 8'h69; carry_in = 1'b0;
            exp = mdl_next(q);
            step;
            chk("R4 enable pattern", q, exp);
        end
        cfg_ce_en = 3'b000; clk_en = 1'b1;
    endtask

    task automatic t_sr_matrix;
        for (int md = 0; md < 2; md++) begin
            for (int en = 0; en < 8; en++) begin
                logic [8:0] cur;
                logic [8:0] exp;
                sr = 1'b0;
                cfg_sr_async = md[0];
                cfg_sr_en = en[2:0];
                dir_in = 8'h3C; carry_in = 1'b0;
                step;
                chk("R7 preload", q, 9'h03C);
                cur = q;
                dir_in = 8'hC3; carry_in = 1'b1;
                sr = 1'b1;
                if (md == 1) begin
                    #1 chk("R6 async force no edge", q, mdl_async(cur));
                end
                exp = mdl_next(cur);
                step;
                chk(md == 1 ? "R6 async held" : "R5 sync at edge R7", q, exp);
                sr = 1'b0;
            end
        end
        cfg_sr_en = 3'b000; cfg_sr_async = 1'b0;
        step;
    endtask

    task automatic t_polarity;
        cfg_ce_en = 3'b111; cfg_ce_inv = 1'b1; clk_en = 1'b1;
        dir_in = 8'h42; carry_in = 1'b0;
        step;
        chk("R8 inverted enable holds", q, 9'h1C3);
        clk_en = 1'b0;
        step;
        chk("R8 inverted enable loads", q, 9'h042);
        cfg_ce_inv = 1'b0; cfg_ce_en = 3'b000;
        cfg_sr_inv = 1'b1; cfg_sr_en = 3'b111; sr = 1'b0;
        step;
        chk("R8 inverted set/reset", q, INIT);
        sr = 1'b1;
        step;
        chk("R8 inverted set/reset idle", q, 9'h042);
        cfg_sel_en = 1'b1; cfg_sel_inv = 1'b1; src_sel = 1'b0; lut_res = 8'hE7;
        step;
        chk("R8 inverted select", q, 9'h0E7);
        cfg_sr_inv = 1'b0; sr = 1'b0; cfg_sr_en = 3'b000;
        cfg_sel_inv = 1'b0; cfg_sel_en = 1'b0;
    endtask

    task automatic t_clk_inv;
        cfg_ce_en = 3'b111; clk_en = 1'b0;
        step;
        cfg_clk_inv = 1'b1;
        clk_en = 1'b1; dir_in = 8'h0F; carry_in = 1'b1;
        #4 chk("R8 capture on falling edge", q, 9'h10F);
        dir_in = 8'hF0; carry_in = 1'b0;
        @(posedge clk);
        #1 chk("R8 rising edge ignored", q, 9'h10F);
        #4 chk("R8 next falling capture", q, 9'h0F0);
        clk_en = 1'b0;
        cfg_clk_inv = 1'b0;
        step;
        cfg_ce_en = 3'b000; clk_en = 1'b1;
    endtask

    initial begin
        glb_rst_n = 1'b0; clk_en = 1'b1; sr = 1'b0; src_sel = 1'b0;
        lut_res = 8'h00; dir_in = 8'h00; carry_in = 1'b0;
        cfg_clk_inv = 1'b0; cfg_ce_inv = 1'b0; cfg_sr_inv = 1'b0;
        cfg_sel_inv = 1'b0; cfg_sel_en = 1'b0; cfg_sr_async = 1'b0;
        cfg_glb_mask = 1'b0; cfg_ce_en = 3'b000; cfg_sr_en = 3'b000;
        cfg_init = INIT;
        t_reset;
        t_mask;
        t_select;
        t_ce_matrix;
        t_sr_matrix;
        t_polarity;
        t_clk_inv;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: q=%h expected completion", q);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule